// File: doc/BRIEF.md
# Pointer authentication gate arbiter

This block makes the gating decision for every pointer-authentication operation a core issues. An operation is described by its kind (sign, authenticate, generic sign or strip), the key it names (instruction A/B, data A/B), and the exception level it runs at. The block evaluates the per-level, per-key enable bits and the two trap controls, the hypervisor one and the secure-monitor one. It then reports one of four actions: proceed, return the operand unchanged, trap to level 2, or trap to level 3. Alongside the action it reports which key the operation uses and, for a trap, the exception-class value to deliver with all syndrome fields zero. Delivering the fault is left to the surrounding pipeline.

The decision is combinational and lands in output registers one clock after a request is presented. A two-state machine tracks the output stage. In `ST_IDLE` no fresh result is held. In `ST_ISSUED` the registers hold the result of the request from the previous cycle. `in_valid` high moves the machine from either state to `ST_ISSUED`. `in_valid` low moves it from either state to `ST_IDLE`. While no request is presented, the result registers keep their last contents.

Top module: `pa_gate_arbiter`

## Requirements
- R1: After reset `out_valid` is 0, `act` is 2'b00, `key_sel` is 0 and `trap_ec` is 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high and 0 otherwise. Without `in_valid`, `act`, `key_sel` and `trap_ec` keep their values whatever the other inputs do.
- R3: The enable bit comes from the vector of the level the operation runs at, with bit index equal to `key_id` (0 IA, 1 IB, 2 DA, 3 DB). At level 0 (`cur_lvl` 2'd0) the level-1 vector `en_l1` is used when `el0_under_l1` is 1, and the level-2 vector `en_l2` otherwise. Levels 1, 2 and 3 use `en_l1`, `en_l2` and `en_l3`.
- R4: A sign (`op_kind` 2'b00) or authenticate (2'b01) operation whose enable bit is 0 yields `act` 2'b01 (pass-through), even when a trap condition holds.
- R5: A level-2 trap condition holds at level 0 when `el2_on` is 1, `hyp_api` is 0 and either `hyp_tge` or `hyp_e2h` is 0. It holds at level 1 when `el2_on` is 1 and `hyp_api` is 0. It never holds at levels 2 and 3. When it decides the outcome, `act` is 2'b10.
- R6: A level-3 trap condition holds at levels 0, 1 and 2 when `el3_here` is 1 and `mon_api` is 0, and never at level 3. When it decides the outcome, `act` is 2'b11.
- R7: If both trap conditions hold, the level-2 trap wins. With neither trap nor pass-through, `act` is 2'b00.
- R8: Generic sign (`op_kind` 2'b10) and strip (2'b11) ignore the enable bits, so they never pass through, and are subject to the traps alone.
- R9: `trap_ec` equals the parameter `TRAP_EC` when `act` is a trap (2'b10 or 2'b11) and 0 otherwise.
- R10: `key_sel` is `key_id` (0 IA, 1 IB, 2 DA, 3 DB) for sign and authenticate, 4 for generic sign and 5 (no key) for strip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is presented this cycle |
| cur_lvl | input | 2 | Exception level of the operation (0..3) |
| op_kind | input | 2 | 00 sign, 01 authenticate, 10 generic sign, 11 strip |
| key_id | input | $clog2(KEY_N) | Named key: 0 IA, 1 IB, 2 DA, 3 DB |
| en_l1 | input | KEY_N | Per-key enables in the level-1 control register |
| en_l2 | input | KEY_N | Per-key enables in the level-2 control register |
| en_l3 | input | KEY_N | Per-key enables in the level-3 control register |
| hyp_api | input | 1 | Hypervisor allow bit; 0 arms level-2 traps |
| hyp_tge | input | 1 | Hypervisor trap-general bit |
| hyp_e2h | input | 1 | Hypervisor host-extension bit |
| mon_api | input | 1 | Secure-monitor allow bit; 0 arms level-3 traps |
| el2_on | input | 1 | Level 2 is enabled in the current state |
| el3_here | input | 1 | Level 3 is implemented |
| el0_under_l1 | input | 1 | Level-0 stage-1 regime is owned by level 1 |
| out_valid | output | 1 | Registered result is fresh |
| act | output | 2 | 00 proceed, 01 pass-through, 10 trap to level 2, 11 trap to level 3 |
| key_sel | output | 3 | Key used: 0..3 as key_id, 4 generic, 5 none |
| trap_ec | output | EC_W | Exception class for a trap, else 0 |

## Verification
On every cycle the assertions check the output handshake and hold behaviour, the pairing of the trap exception class with a trap action, and several invariants. Level 3 never traps, level 2 never traps to itself, generic sign and strip never pass through, and generic sign always selects key 4. The full decision depends on the exact interplay of the level, the regime owner, the three enable vectors and the trap bits. Only the bench's sweep over level, operation, key, every trap-control combination and several enable patterns shows that interplay, including the priority of pass-through over traps and of the level-2 trap over the level-3 trap.

// File: rtl/pa_arb_pkg.sv
package pa_arb_pkg;

    localparam int LVL_W  = 2;
    localparam int OPK_W  = 2;
    localparam int ACT_W  = 2;
    localparam int KSEL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } lvl_e;

    typedef enum logic [OPK_W-1:0] {
        OPK_SIGN    = 2'b00,
        OPK_AUTH    = 2'b01,
        OPK_GENERIC = 2'b10,
        OPK_STRIP   = 2'b11
    } opk_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_PROCEED = 2'b00,
        ACT_PASS    = 2'b01,
        ACT_TRAP_L2 = 2'b10,
        ACT_TRAP_L3 = 2'b11
    } act_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ISSUED = 1'b1
    } ostate_e;

    localparam logic [KSEL_W-1:0] KSEL_GA   = 3'd4;
    localparam logic [KSEL_W-1:0] KSEL_NONE = 3'd5;

endpackage

// File: rtl/pa_en_pick.sv
// Selects the enable bit that governs the named key at the current level.
module pa_en_pick
    import pa_arb_pkg::*;
#(
    parameter  int KEY_N = 4,
    localparam int KID_W = $clog2(KEY_N)
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic             regime_l1,
    input  logic [KID_W-1:0] key_id,
    input  logic [KEY_N-1:0] en_l1,
    input  logic [KEY_N-1:0] en_l2,
    input  logic [KEY_N-1:0] en_l3,
    output logic             en_bit
);

    logic [KEY_N-1:0] eff;

    // Per-key level mux; level 0 borrows the register of its regime owner.
    for (genvar k = 0; k < KEY_N; k++) begin : g_key
        assign eff[k] = (lvl == LVL_0) ? (regime_l1 ? en_l1[k] : en_l2[k]) :
                        (lvl == LVL_1) ? en_l1[k] :
                        (lvl == LVL_2) ? en_l2[k] :
                                         en_l3[k];
    end

    assign en_bit = eff[key_id];

endmodule

// File: rtl/pa_trap_eval.sv
// Evaluates the two trap conditions for the current level.
module pa_trap_eval
    import pa_arb_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic             el2_on,
    input  logic             hyp_api,
    input  logic             hyp_tge,
    input  logic             hyp_e2h,
    input  logic             el3_here,
    input  logic             mon_api,
    output logic             trap_l2,
    output logic             trap_l3
);

    lvl_e lv;
    assign lv = lvl_e'(lvl);

    always_comb begin
        trap_l2 = 1'b0;
        trap_l3 = 1'b0;
        unique case (lv)
            LVL_0: begin
                trap_l2 = el2_on && !hyp_api && (!hyp_tge || !hyp_e2h);
                trap_l3 = el3_here && !mon_api;
            end
            LVL_1: begin
                trap_l2 = el2_on && !hyp_api;
                trap_l3 = el3_here && !mon_api;
            end
            LVL_2: begin
                trap_l3 = el3_here && !mon_api;
            end
            LVL_3: begin
                trap_l2 = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pa_resolve.sv
// Applies the priority between pass-through and the traps; picks the key.
module pa_resolve
    import pa_arb_pkg::*;
#(
    parameter  int              KEY_N   = 4,
    parameter  int              EC_W    = 6,
    parameter  logic [EC_W-1:0] TRAP_EC = 6'h09,
    localparam int              KID_W   = $clog2(KEY_N)
) (
    input  logic [OPK_W-1:0]  opk,
    input  logic [KID_W-1:0]  key_id,
    input  logic              en_bit,
    input  logic              trap_l2,
    input  logic              trap_l3,
    output logic [ACT_W-1:0]  act,
    output logic [KSEL_W-1:0] ksel,
    output logic [EC_W-1:0]   ec
);

    opk_e op;
    act_e res;
    logic gated;

    assign op = opk_e'(opk);

    always_comb begin
        gated = 1'b0;
        ksel  = KSEL_NONE;
        unique case (op)
            OPK_SIGN, OPK_AUTH: begin
                gated = 1'b1;
                ksel  = KSEL_W'(key_id);
            end
            OPK_GENERIC: ksel = KSEL_GA;
            OPK_STRIP:   ksel = KSEL_NONE;
        endcase
    end

    always_comb begin
        if (gated && !en_bit)  res = ACT_PASS;
        else if (trap_l2)      res = ACT_TRAP_L2;
        else if (trap_l3)      res = ACT_TRAP_L3;
        else                   res = ACT_PROCEED;
    end

    assign act = res;
    assign ec  = (res == ACT_TRAP_L2 || res == ACT_TRAP_L3) ? TRAP_EC : '0;

endmodule

// File: rtl/pa_gate_arbiter.sv
// Top: decision path plus registered result stage tracked by a small FSM.
module pa_gate_arbiter
    import pa_arb_pkg::*;
#(
    parameter  int              KEY_N   = 4,
    parameter  int              EC_W    = 6,
    parameter  logic [EC_W-1:0] TRAP_EC = 6'h09,
    localparam int              KID_W   = $clog2(KEY_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        cur_lvl,
    input  logic [1:0]        op_kind,
    input  logic [KID_W-1:0]  key_id,
    input  logic [KEY_N-1:0]  en_l1,
    input  logic [KEY_N-1:0]  en_l2,
    input  logic [KEY_N-1:0]  en_l3,
    input  logic              hyp_api,
    input  logic              hyp_tge,
    input  logic              hyp_e2h,
    input  logic              mon_api,
    input  logic              el2_on,
    input  logic              el3_here,
    input  logic              el0_under_l1,
    output logic              out_valid,
    output logic [1:0]        act,
    output logic [2:0]        key_sel,
    output logic [EC_W-1:0]   trap_ec
);

    logic              en_bit;
    logic              trap_l2;
    logic              trap_l3;
    logic [ACT_W-1:0]  act_d;
    logic [KSEL_W-1:0] ksel_d;
    logic [EC_W-1:0]   ec_d;

    ostate_e state_q;
    ostate_e state_d;

    pa_en_pick #(.KEY_N(KEY_N)) u_en (
        .lvl       (cur_lvl),
        .regime_l1 (el0_under_l1),
        .key_id    (key_id),
        .en_l1     (en_l1),
        .en_l2     (en_l2),
        .en_l3     (en_l3),
        .en_bit    (en_bit)
    );

    pa_trap_eval u_trap (
        .lvl      (cur_lvl),
        .el2_on   (el2_on),
        .hyp_api  (hyp_api),
        .hyp_tge  (hyp_tge),
        .hyp_e2h  (hyp_e2h),
        .el3_here (el3_here),
        .mon_api  (mon_api),
        .trap_l2  (trap_l2),
        .trap_l3  (trap_l3)
    );

    pa_resolve #(.KEY_N(KEY_N), .EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_res (
        .opk     (op_kind),
        .key_id  (key_id),
        .en_bit  (en_bit),
        .trap_l2 (trap_l2),
        .trap_l3 (trap_l3),
        .act     (act_d),
        .ksel    (ksel_d),
        .ec      (ec_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_ISSUED : ST_IDLE;
            ST_ISSUED: state_d = in_valid ? ST_ISSUED : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= ACT_PROCEED;
            key_sel <= '0;
            trap_ec <= '0;
        end else if (in_valid) begin
            act     <= act_d;
            key_sel <= ksel_d;
            trap_ec <= ec_d;
        end
    end

    assign out_valid = (state_q == ST_ISSUED);

endmodule

// File: rtl/pa_gate_arbiter_chk.sv
module pa_gate_arbiter_chk #(
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h09
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      cur_lvl,
    input logic [1:0]      op_kind,
    input logic            out_valid,
    input logic [1:0]      act,
    input logic [2:0]      key_sel,
    input logic [EC_W-1:0] trap_ec
);

    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(act) && $stable(key_sel) && $stable(trap_ec)));

    p_top_no_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_lvl == 2'd3) |=> !act[1]);

    p_l2_no_self_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_lvl == 2'd2) |=> (act != 2'b10));

    p_bypass_no_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind[1]) |=> (act != 2'b01));

    p_generic_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b10) |=> (key_sel == 3'd4));

    p_ec_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act[1] |-> (trap_ec == TRAP_EC));

    p_ec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !act[1] |-> (trap_ec == '0));

endmodule

bind pa_gate_arbiter pa_gate_arbiter_chk #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cur_lvl   (cur_lvl),
    .op_kind   (op_kind),
    .out_valid (out_valid),
    .act       (act),
    .key_sel   (key_sel),
    .trap_ec   (trap_ec)
);

// File: tb/pa_gate_arbiter_test.sv
module pa_gate_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int EC_W = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h09;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] cur_lvl = '0;
    logic [1:0] op_kind = '0;
    logic [1:0] key_id = '0;
    logic [3:0] en_l1 = '0, en_l2 = '0, en_l3 = '0;
    logic hyp_api = 0, hyp_tge = 0, hyp_e2h = 0, mon_api = 0;
    logic el2_on = 0, el3_here = 0, el0_under_l1 = 0;
    logic out_valid;
    logic [1:0] act;
    logic [2:0] key_sel;
    logic [EC_W-1:0] trap_ec;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pa_gate_arbiter #(.KEY_N(4), .EC_W(EC_W), .TRAP_EC(TRAP_EC)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_lvl(cur_lvl),
        .op_kind(op_kind), .key_id(key_id), .en_l1(en_l1), .en_l2(en_l2),
        .en_l3(en_l3), .hyp_api(hyp_api), .hyp_tge(hyp_tge), .hyp_e2h(hyp_e2h),
        .mon_api(mon_api), .el2_on(el2_on), .el3_here(el3_here),
        .el0_under_l1(el0_under_l1), .out_valid(out_valid), .act(act),
        .key_sel(key_sel), .trap_ec(trap_ec)
    );

    logic [1:0] e_act;
    logic [2:0] e_key;
    logic [EC_W-1:0] e_ec;
    string e_tag;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Reference decision from the requirements.
    task automatic model();
        logic [3:0] vec;
        logic en, t2, t3;
        case (cur_lvl)
            2'd0: vec = el0_under_l1 ? en_l1 : en_l2;   // R3
            2'd1: vec = en_l1;
            2'd2: vec = en_l2;
            default: vec = en_l3;
        endcase
        en = vec[key_id];
        t2 = el2_on && !hyp_api &&
             ((cur_lvl == 2'd0 && !(hyp_tge && hyp_e2h)) || cur_lvl == 2'd1);  // R5
        t3 = el3_here && !mon_api && cur_lvl != 2'd3;                         // R6
        if (!op_kind[1] && !en) begin e_act = 2'b01; e_tag = "R4"; end
        else if (t2) begin e_act = 2'b10; e_tag = t3 ? "R7" : "R5"; end
        else if (t3) begin e_act = 2'b11; e_tag = "R6"; end
        else begin e_act = 2'b00; e_tag = op_kind[1] ? "R8" : "R3"; end
        if (op_kind[1] && e_act != 2'b00) e_tag = "R8";
        e_key = (op_kind == 2'b10) ? 3'd4 : (op_kind == 2'b11) ? 3'd5 : {1'b0, key_id};  // R10
        e_ec  = e_act[1] ? TRAP_EC : '0;                                                 // R9
    endtask

    task automatic check_result();
        chk("R2", "out_valid", 32'(out_valid), 32'd1);
        chk(e_tag, "act", 32'(act), 32'(e_act));
        chk("R10", "key_sel", 32'(key_sel), 32'(e_key));
        chk("R9", "trap_ec", 32'(trap_ec), 32'(e_ec));
    endtask

    initial begin
        bit have = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "act", 32'(act), 32'd0);
        chk("R1", "key_sel", 32'(key_sel), 32'd0);
        chk("R1", "trap_ec", 32'(trap_ec), 32'd0);
        rst_n = 1'b1;

        for (int e = 0; e < 16; e += 3) begin
            for (int lv = 0; lv < 4; lv++) begin
                for (int ok = 0; ok < 4; ok++) begin
                    for (int k = 0; k < 4; k++) begin
                        for (int m = 0; m < 128; m++) begin
                            @(negedge clk);
                            if (have) check_result();
                            in_valid = 1'b1;
                            cur_lvl = 2'(lv);
                            op_kind = 2'(ok);
                            key_id = 2'(k);
                            en_l1 = 4'(e);
                            en_l2 = ~4'(e);
                            en_l3 = {4'(e) << 1} | (4'(e) >> 3);
                            {hyp_api, hyp_tge, hyp_e2h, mon_api,
                             el2_on, el3_here, el0_under_l1} = 7'(m);
                            model();
                            have = 1;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        check_result();
        in_valid = 1'b0;

        // R2: with no request, changing inputs must not disturb the held result.
        for (int i = 0; i < 3; i++) begin
            cur_lvl = 2'(i);
            op_kind = 2'(i + 1);
            en_l1 = 4'h0; en_l2 = 4'h0; en_l3 = 4'h0;
            el2_on = 1'b1; hyp_api = 1'b0;
            @(negedge clk);
            chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
            chk("R2", "act held", 32'(act), 32'(e_act));
            chk("R2", "key_sel held", 32'(key_sel), 32'(e_key));
            chk("R2", "trap_ec held", 32'(trap_ec), 32'(e_ec));
        end

        // Fresh request after idle: level-0 sign IB, disabled in owner register.
        in_valid = 1'b1; cur_lvl = 2'd0; op_kind = 2'b00; key_id = 2'd1;
        el0_under_l1 = 1'b1; en_l1 = 4'b1101; en_l2 = 4'b1111;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        check_result();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule